// File: doc/BRIEF.md
# Break Input Glitch Filter

This block cleans up an asynchronous break (fault) level before a break controller acts on it. A 4-bit setting picks one of sixteen behaviours. Setting 0 bypasses all conditioning, so the output follows the input with no clock involved. Every other setting first synchronizes the input through two flops. It then samples the result at a chosen rate and changes the output level only after a fixed count of consecutive samples has shown the new level.

The sampling rate is either every timer clock or a divided rate. The divided rate comes from counting pulses of a dead-time clock enable. Slow settings reject longer glitches. Fast settings react within a few cycles.

Top module: `brk_filt`

## Requirements
- R1: With setting 0 the output equals the break input combinationally, in the same cycle and with no sampling.
- R2: Settings 1, 2 and 3 take a sample on every timer clock and need 2, 4 and 8 matching samples.
- R3: Settings 4 and 5 take one sample per 2 dead-time enable pulses and need 6 and 8 matching samples.
- R4: Settings 6 and 7 sample once per 4 enable pulses, and settings 8 and 9 once per 8. Settings 6 and 8 need 6 matching samples; settings 7 and 9 need 8.
- R5: Settings 10, 11 and 12 sample once per 16 enable pulses, and settings 13, 14 and 15 once per 32. In each group of three the settings need 5, 6 and 8 matching samples, in that order.
- R6: In a filtered setting the output takes a new level only after N consecutive samples show that level. N-1 samples are rejected. This holds for both rising and falling changes.
- R7: A sample equal to the present output level clears the match count. Two runs of N-1 samples separated by one opposing sample are rejected.
- R8: While reset is asserted the output is low, whatever the break input is.
- R9: A change of setting clears the match count and the sample divider. Samples taken before the change do not count toward the new setting.
- R10: Divided settings count dead-time enable pulses, not timer clocks. Gaps in the enable stretch the sampling period accordingly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | Asynchronous raw break level |
| cfg_i | input | 4 | Filter setting (0 = bypass, 1..15 = filtered) |
| dts_en_i | input | 1 | Dead-time clock enable, one pulse per dead-time tick |
| brk_o | output | 1 | Filtered break level |

## Verification
Several properties are checked on every cycle. Bypass transparency is one. The filtered level holds between sampling instants. A level flip happens only when the count has reached N-1 under an unchanged setting. The count stays below N, and it clears after a setting change.

Some behaviours only the bench scenarios can show. These are the exact sample counts and divider ratios for each setting: N-1 is rejected and N passes, for all fifteen filtered settings. The same scenarios cover the restart after an opposing glitch, the discarding of counts across a setting change, and the stretching of the sampling period by gaps in the enable.

// File: rtl/brk_filt_pkg.sv
package brk_filt_pkg;
  localparam int CFG_W = 4;
  localparam int CNT_W = 4;
  localparam int DIV_W = 5;
  localparam int SH_W  = 3;

  typedef struct packed {
    logic             use_dts;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] n;
  } flt_mode_t;

  function automatic flt_mode_t decode_mode(logic [CFG_W-1:0] c);
    flt_mode_t m;
    m = '{use_dts: 1'b1, sh: SH_W'(0), n: CNT_W'(1)};
    case (c)
      4'd0:  m = '{1'b0, SH_W'(0), CNT_W'(1)};
      4'd1:  m = '{1'b0, SH_W'(0), CNT_W'(2)};
      4'd2:  m = '{1'b0, SH_W'(0), CNT_W'(4)};
      4'd3:  m = '{1'b0, SH_W'(0), CNT_W'(8)};
      4'd4:  m = '{1'b1, SH_W'(1), CNT_W'(6)};
      4'd5:  m = '{1'b1, SH_W'(1), CNT_W'(8)};
      4'd6:  m = '{1'b1, SH_W'(2), CNT_W'(6)};
      4'd7:  m = '{1'b1, SH_W'(2), CNT_W'(8)};
      4'd8:  m = '{1'b1, SH_W'(3), CNT_W'(6)};
      4'd9:  m = '{1'b1, SH_W'(3), CNT_W'(8)};
      4'd10: m = '{1'b1, SH_W'(4), CNT_W'(5)};
      4'd11: m = '{1'b1, SH_W'(4), CNT_W'(6)};
      4'd12: m = '{1'b1, SH_W'(4), CNT_W'(8)};
      4'd13: m = '{1'b1, SH_W'(5), CNT_W'(5)};
      4'd14: m = '{1'b1, SH_W'(5), CNT_W'(6)};
      default: m = '{1'b1, SH_W'(5), CNT_W'(8)};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/brk_stb_gen.sv
module brk_stb_gen
  import brk_filt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            use_dts_i,
  input  logic [SH_W-1:0] sh_i,
  input  logic            dts_en_i,
  output logic            stb_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  always_comb begin
    span = (DIV_W+1)'(1) << sh_i;
    lim  = DIV_W'(span - 1'b1);
    wrap = dts_en_i && (div_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (clr_i || !use_dts_i) div_q <= '0;
    else if (wrap)               div_q <= '0;
    else if (dts_en_i)           div_q <= div_q + 1'b1;
  end

  assign stb_o = use_dts_i ? wrap : 1'b1;
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             track_i,
  input  logic             stb_i,
  input  logic             smp_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             lvl_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (track_i) begin
      lvl_q <= smp_i;   // follow input while bypassed
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (smp_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == n_i - 1'b1) begin
        lvl_q <= smp_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/brk_filt.sv
module brk_filt
  import brk_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             brk_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             dts_en_i,
  output logic             brk_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             bypass;
  flt_mode_t        mode;
  logic             brk_s;
  logic             smp_stb;
  logic             flt_lvl;
  logic [CNT_W-1:0] match_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  assign cfg_chg = (cfg_i != cfg_q);
  assign bypass  = (cfg_i == '0);
  assign mode    = decode_mode(cfg_i);

  brk_sync #(.STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (brk_i),
    .q_o    (brk_s)
  );

  brk_stb_gen i_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_chg),
    .use_dts_i (mode.use_dts),
    .sh_i      (mode.sh),
    .dts_en_i  (dts_en_i),
    .stb_o     (smp_stb)
  );

  brk_match i_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_chg),
    .track_i (bypass),
    .stb_i   (smp_stb),
    .smp_i   (brk_s),
    .n_i     (mode.n),
    .lvl_o   (flt_lvl),
    .cnt_o   (match_cnt)
  );

  assign brk_o = bypass ? brk_i : flt_lvl;
endmodule

// File: rtl/brk_filt_chk.sv
module brk_filt_chk
  import brk_filt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             brk_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             brk_o,
  input logic [CFG_W-1:0] cfg_q_i,
  input logic             stb_i,
  input logic             lvl_i,
  input logic [CNT_W-1:0] cnt_i
);
  flt_mode_t cur_mode;
  flt_mode_t old_mode;
  assign cur_mode = decode_mode(cfg_i);
  assign old_mode = decode_mode(cfg_q_i);

  AST_BYPASS_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == '0) |-> (brk_o == brk_i)); // R1

  AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != '0 && !stb_i) |=> $stable(lvl_i)); // R6

  AST_FLIP_AFTER_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lvl_i) && $past(cfg_i) != '0) |->
      ($past(stb_i) && $past(cfg_i) == $past(cfg_q_i) &&
       $past(cnt_i) == $past(cur_mode.n) - 1'b1)); // R6

  AST_CNT_BELOW_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < old_mode.n)); // R7

  AST_CFG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != cfg_q_i) |=> (cnt_i == '0)); // R9
endmodule

bind brk_filt brk_filt_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .brk_i   (brk_i),
  .cfg_i   (cfg_i),
  .brk_o   (brk_o),
  .cfg_q_i (cfg_q),
  .stb_i   (smp_stb),
  .lvl_i   (flt_lvl),
  .cnt_i   (match_cnt)
);

// File: tb/test_brk_filt.sv
module test_brk_filt;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       brk_i = 1'b0;
  logic [3:0] cfg_i = 4'd1;
  logic       dts_en_i = 1'b1;
  logic       brk_o;

  int total = 0;
  int bad = 0;
  int gap = 1;
  int gc = 0;
  logic seen = 1'b0;

  // {setting, N, divide}
  localparam logic [13:0] VEC [15] = '{
    {4'd1,  4'd2, 6'd1},  {4'd2,  4'd4, 6'd1},  {4'd3,  4'd8, 6'd1},
    {4'd4,  4'd6, 6'd2},  {4'd5,  4'd8, 6'd2},  {4'd6,  4'd6, 6'd4},
    {4'd7,  4'd8, 6'd4},  {4'd8,  4'd6, 6'd8},  {4'd9,  4'd8, 6'd8},
    {4'd10, 4'd5, 6'd16}, {4'd11, 4'd6, 6'd16}, {4'd12, 4'd8, 6'd16},
    {4'd13, 4'd5, 6'd32}, {4'd14, 4'd6, 6'd32}, {4'd15, 4'd8, 6'd32}
  };

  brk_filt i_brk_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .brk_i    (brk_i),
    .cfg_i    (cfg_i),
    .dts_en_i (dts_en_i),
    .brk_o    (brk_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (gc + 1 >= gap) begin gc <= 0; dts_en_i <= 1'b1; end
    else begin gc <= gc + 1; dts_en_i <= 1'b0; end
  end

  always @(brk_o) if (brk_o === 1'b1) seen = 1'b1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic pulse(input int cyc);
    @(negedge clk_i) brk_i = 1'b1;
    repeat (cyc) @(negedge clk_i);
    brk_i = 1'b0;
  endtask

  task automatic run_vec(input int cfg, input int n, input int d, input string tag);
    int per;
    per = d * gap;
    cfg_i = 4'(cfg);
    settle(4);
    seen = 1'b0;
    pulse((n - 1) * per);
    settle((n + 4) * per + 6);
    chk(!seen, $sformatf("R6 reject cfg=%0d", cfg), int'(seen), 0);
    seen = 1'b0;
    pulse(n * per);
    settle((n + 4) * per + 6);
    chk(seen, $sformatf("%s pass cfg=%0d", tag, cfg), int'(seen), 1);
    chk(brk_o == 1'b0, $sformatf("R6 fall cfg=%0d", cfg), int'(brk_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset holds the output low
    brk_i = 1'b1;
    settle(4);
    chk(brk_o == 1'b0, "R8 reset", int'(brk_o), 0);
    brk_i = 1'b0;
    settle(3);
    rst_ni = 1'b1;
    settle(4);
    chk(brk_o == 1'b0, "R8 after reset", int'(brk_o), 0);

    // table walk: R2..R6
    foreach (VEC[i]) begin
      int c;
      string tag;
      c = int'(VEC[i][13:10]);
      tag = (c <= 3) ? "R2" : (c <= 5) ? "R3" : (c <= 9) ? "R4" : "R5";
      run_vec(c, int'(VEC[i][9:6]), int'(VEC[i][5:0]), tag);
    end

    // R10: enable every other clock halves the sampling rate
    gap = 2;
    run_vec(5, 8, 2, "R10");
    run_vec(9, 8, 8, "R10");
    gap = 1;
    settle(4);

    // R1: bypass is combinational
    @(negedge clk_i) cfg_i = 4'd0;
    brk_i = 1'b1;
    #1 chk(brk_o == 1'b1, "R1 bypass high", int'(brk_o), 1);
    brk_i = 1'b0;
    #1 chk(brk_o == 1'b0, "R1 bypass low", int'(brk_o), 0);

    // R7: opposing sample restarts count (N=4)
    @(negedge clk_i) cfg_i = 4'd2;
    settle(6);
    seen = 1'b0;
    brk_i = 1'b1; settle(3);
    brk_i = 1'b0; settle(1);
    brk_i = 1'b1; settle(3);
    brk_i = 1'b0; settle(12);
    chk(!seen, "R7 glitch restart", int'(seen), 0);

    // R9: counts from before a setting change are discarded
    settle(4);
    seen = 1'b0;
    brk_i = 1'b1; settle(5);
    cfg_i = 4'd3; settle(6);
    brk_i = 1'b0; settle(20);
    chk(!seen, "R9 restart on change", int'(seen), 0);
    chk(brk_o == 1'b0, "R9 level", int'(brk_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule